// File: doc/BRIEF.md
# PWM Carrier Chopper

The chopper sits between a PWM generator and the output drivers and handles two PWM channels, A and B. When enabled, every high interval of a channel is broken into a high-frequency pulse train. That train is taken from a carrier derived from the PWM clock. A programmable prescaler sets the carrier rate, and the carrier duty is set in eighths. Each high interval opens with one wider pulse that lasts a programmable number of carrier periods. The chopped train follows it. Each channel's input and output polarity can be flipped. When the chopper is disabled, the channels pass through unchanged, apart from the output polarity flip.

Configuration arrives as one 32-bit word that resets to zero. The word is sampled live on every cycle. Both inputs are registered once, so every output lags its input by one clock. The two channels share one carrier generator, and each channel has its own one-shot counter. A rising edge on either channel restarts the shared carrier phase. The PWM signals are level signals with no handshake, so the block has no valid/ready interface and cannot apply back-pressure.

Top module: `pwm_chopper`

## Requirements
- R1: After reset, all internal state is clear. With a zero configuration word and both inputs low, both outputs are low.
- R2: When the enable bit (bit 0) is 0, each output equals its post-inversion input one cycle earlier, with the output inversion applied.
- R3: When bit 13 is 1, both inputs are inverted before edge detection, bypass and chopping.
- R4: When bit 12 is 1, both outputs are inverted after the bypass/chop selection. This holds whether or not the chopper is enabled.
- R5: When enabled, a channel whose registered post-inversion input is low drives its inactive level. The inactive level is 0, or 1 when bit 12 is set.
- R6: The carrier phase advances once every P+1 clocks, where P is the value in bits 4:1. A carrier period is 8·(P+1) clocks.
- R7: The carrier is high for the first D of its 8 phases, where D is the value in bits 7:5. With D = 0, and once the first pulse has ended, an enabled channel with a high input stays at its inactive level.
- R8: Each rising edge of a channel's post-inversion input loads W, the value in bits 11:8, into that channel's one-shot. The output stays active for W complete carrier periods. After that it follows the input ANDed with the carrier. A high run opened from a restarted carrier therefore lasts W·8·(P+1)+D·(P+1) clocks.
- R9: A rising edge on either channel resets the shared prescale and phase counters. A carrier period cut short by such an edge does not count towards either channel's one-shot.
- R10: The output responds to a change of input on the clock edge after the change and not earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | PWM clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_word | input | 32 | Configuration word: enable, prescale, duty, first-pulse width, output and input inversion |
| pwm_in | input | 2 | PWM inputs; bit 0 is channel A, bit 1 is channel B |
| pwm_out | output | 2 | Chopped or bypassed PWM outputs, same bit order |

## Verification
Long steady high inputs are used with several prescale and duty pairs. These runs separate the carrier period from the duty and expose off-by-one errors in the prescaler wrap. A wide first pulse followed by a direct count of the active run shows whether the one-shot counts whole carrier periods or clocks. Pseudo-random toggling of both channels together makes one channel's rising edge restart the carrier while the other channel is mid-interval. This exercises the shared restart and keeps each channel's one-shot separate. Each of these patterns is repeated with the chopper disabled and with each inversion bit set, which shows where in the path each bit acts.

// File: rtl/chop_pkg.sv
`timescale 1ns/1ps
package chop_pkg;
  localparam int DEF_NUM_CH = 2;
  localparam int DEF_PS_W   = 4;
  localparam int DEF_PH_W   = 3;
  localparam int DEF_OS_W   = 4;
  localparam int DEF_CFG_W  = 32;
  localparam int CH_A = 0;
  localparam int CH_B = 1;
endpackage

// File: rtl/chop_carrier_gen.sv
`timescale 1ns/1ps
module chop_carrier_gen #(
  parameter int PS_W = 4,
  parameter int PH_W = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            restart,
  input  logic [PS_W-1:0] prescale,
  input  logic [PH_W-1:0] duty,
  output logic [PS_W-1:0] pc,
  output logic [PH_W-1:0] ph,
  output logic            carrier,
  output logic            period_end
);
  localparam logic [PH_W-1:0] PH_LAST = {PH_W{1'b1}};

  logic tick;

  // wrap on >= so a prescale shrunk below the count still wraps promptly
  assign tick       = (pc >= prescale);
  assign period_end = tick && (ph == PH_LAST);
  assign carrier    = (ph < duty);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc <= '0;
      ph <= '0;
    end else if (restart) begin
      pc <= '0;
      ph <= '0;
    end else if (tick) begin
      pc <= '0;
      ph <= ph + 1'b1;
    end else begin
      pc <= pc + 1'b1;
    end
  end
endmodule

// File: rtl/chop_channel.sv
`timescale 1ns/1ps
module chop_channel #(
  parameter int OS_W = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            pin,
  input  logic            in_inv,
  input  logic            out_inv,
  input  logic            enable,
  input  logic [OS_W-1:0] width,
  input  logic            carrier,
  input  logic            period_end,
  input  logic            rise_any,
  output logic            x_q,
  output logic            rise,
  output logic            os_busy,
  output logic            pout
);
  logic            x_now;
  logic [OS_W-1:0] os_cnt;
  logic            chopped;

  assign x_now   = pin ^ in_inv;
  assign rise    = x_now & ~x_q;
  assign os_busy = (os_cnt != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      x_q    <= 1'b0;
      os_cnt <= '0;
    end else begin
      x_q <= x_now;
      if (rise) begin
        os_cnt <= width;
      end else if (period_end && !rise_any && os_busy) begin
        os_cnt <= os_cnt - 1'b1;
      end
    end
  end

  assign chopped = x_q & (os_busy | carrier);
  assign pout    = (enable ? chopped : x_q) ^ out_inv;
endmodule

// File: rtl/pwm_chopper.sv
`timescale 1ns/1ps
module pwm_chopper
  import chop_pkg::*;
#(
  parameter int NUM_CH = DEF_NUM_CH,
  parameter int PS_W   = DEF_PS_W,
  parameter int PH_W   = DEF_PH_W,
  parameter int OS_W   = DEF_OS_W,
  parameter int CFG_W  = DEF_CFG_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CFG_W-1:0]  cfg_word,
  input  logic [NUM_CH-1:0] pwm_in,
  output logic [NUM_CH-1:0] pwm_out
);
  localparam int EN_BIT   = 0;
  localparam int PS_LSB   = EN_BIT + 1;
  localparam int PH_LSB   = PS_LSB + PS_W;
  localparam int OS_LSB   = PH_LSB + PH_W;
  localparam int OINV_BIT = OS_LSB + OS_W;
  localparam int IINV_BIT = OINV_BIT + 1;
  localparam int USED_W   = IINV_BIT + 1;

  logic            cfg_en;
  logic [PS_W-1:0] cfg_ps;
  logic [PH_W-1:0] cfg_duty;
  logic [OS_W-1:0] cfg_width;
  logic            cfg_oinv;
  logic            cfg_iinv;
  logic            unused_cfg_hi;

  assign cfg_en        = cfg_word[EN_BIT];
  assign cfg_ps        = cfg_word[PS_LSB +: PS_W];
  assign cfg_duty      = cfg_word[PH_LSB +: PH_W];
  assign cfg_width     = cfg_word[OS_LSB +: OS_W];
  assign cfg_oinv      = cfg_word[OINV_BIT];
  assign cfg_iinv      = cfg_word[IINV_BIT];
  assign unused_cfg_hi = ^cfg_word[CFG_W-1:USED_W];

  logic [NUM_CH-1:0] x_q;
  logic [NUM_CH-1:0] rise;
  logic [NUM_CH-1:0] os_busy;
  logic              rise_any;
  logic [PS_W-1:0]   pc;
  logic [PH_W-1:0]   ph;
  logic              carrier;
  logic              period_end;

  assign rise_any = |rise;

  chop_carrier_gen #(.PS_W(PS_W), .PH_W(PH_W)) u_car (
    .clk        (clk),
    .rst_n      (rst_n),
    .restart    (rise_any),
    .prescale   (cfg_ps),
    .duty       (cfg_duty),
    .pc         (pc),
    .ph         (ph),
    .carrier    (carrier),
    .period_end (period_end)
  );

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    chop_channel #(.OS_W(OS_W)) u_ch (
      .clk        (clk),
      .rst_n      (rst_n),
      .pin        (pwm_in[g]),
      .in_inv     (cfg_iinv),
      .out_inv    (cfg_oinv),
      .enable     (cfg_en),
      .width      (cfg_width),
      .carrier    (carrier),
      .period_end (period_end),
      .rise_any   (rise_any),
      .x_q        (x_q[g]),
      .rise       (rise[g]),
      .os_busy    (os_busy[g]),
      .pout       (pwm_out[g])
    );
  end
endmodule

// File: rtl/pwm_chopper_chk.sv
`timescale 1ns/1ps
module pwm_chopper_chk #(
  parameter int NUM_CH = 2,
  parameter int PS_W   = 4,
  parameter int PH_W   = 3,
  parameter int OS_W   = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cfg_en,
  input logic [PH_W-1:0]   cfg_duty,
  input logic [OS_W-1:0]   cfg_width,
  input logic              cfg_oinv,
  input logic              cfg_iinv,
  input logic [NUM_CH-1:0] pwm_in,
  input logic [NUM_CH-1:0] pwm_out,
  input logic [NUM_CH-1:0] x_q,
  input logic [NUM_CH-1:0] rise,
  input logic [NUM_CH-1:0] os_busy,
  input logic [PS_W-1:0]   pc,
  input logic [PH_W-1:0]   ph
);
  logic seen;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) seen <= 1'b0;
    else        seen <= 1'b1;
  end

  AST_CARRIER_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    (|rise) |=> (pc == '0 && ph == '0)); // R9

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ast
    AST_BYPASS_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n)
      (seen && !cfg_en && $stable(cfg_iinv) && $stable(cfg_oinv))
      |-> (pwm_out[g] == ($past(pwm_in[g]) ^ cfg_iinv ^ cfg_oinv))); // R2
    AST_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_en && !x_q[g]) |-> (pwm_out[g] == cfg_oinv)); // R5
    AST_ONESHOT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_en && x_q[g] && os_busy[g]) |-> (pwm_out[g] == !cfg_oinv)); // R8
    AST_ONESHOT_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      (rise[g] && cfg_width != '0) |=> os_busy[g]); // R8
    AST_NO_CARRIER: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_en && x_q[g] && !os_busy[g] && cfg_duty == '0)
      |-> (pwm_out[g] == cfg_oinv)); // R7
  end
endmodule

bind pwm_chopper pwm_chopper_chk #(
  .NUM_CH (NUM_CH),
  .PS_W   (PS_W),
  .PH_W   (PH_W),
  .OS_W   (OS_W)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cfg_en    (cfg_en),
  .cfg_duty  (cfg_duty),
  .cfg_width (cfg_width),
  .cfg_oinv  (cfg_oinv),
  .cfg_iinv  (cfg_iinv),
  .pwm_in    (pwm_in),
  .pwm_out   (pwm_out),
  .x_q       (x_q),
  .rise      (rise),
  .os_busy   (os_busy),
  .pc        (pc),
  .ph        (ph)
);

// File: tb/pwm_chopper_tb.sv
`timescale 1ns/1ps
module pwm_chopper_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] cfg_word = 32'h0;
  logic [1:0]  pwm_in = 2'b00;
  logic [1:0]  pwm_out;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  bit cmp_on = 1'b0;
  string cur_req = "R1";

  always #2.5 clk = ~clk;

  pwm_chopper u_dut (
    .clk      (clk),
    .rst_n    (rst_n),
    .cfg_word (cfg_word),
    .pwm_in   (pwm_in),
    .pwm_out  (pwm_out)
  );

  // behavioural reference: time since last carrier restart, per-channel one-shot budget
  int T;
  int os_m [2];
  bit xq_m [2];

  function automatic int f_p(); return int'(cfg_word[4:1]); endfunction
  function automatic int f_d(); return int'(cfg_word[7:5]); endfunction
  function automatic int f_w(); return int'(cfg_word[11:8]); endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      T = 0;
      for (int c = 0; c < 2; c++) begin os_m[c] = 0; xq_m[c] = 1'b0; end
    end else begin
      bit xn [2];
      bit rs [2];
      int len;
      len = 8 * (f_p() + 1);
      for (int c = 0; c < 2; c++) begin
        xn[c] = pwm_in[c] ^ cfg_word[13];
        rs[c] = xn[c] && !xq_m[c];
      end
      if (rs[0] || rs[1]) begin
        T = 0;
        for (int c = 0; c < 2; c++) if (rs[c]) os_m[c] = f_w();
      end else begin
        if ((T % len) == len - 1)
          for (int c = 0; c < 2; c++) if (os_m[c] > 0) os_m[c] = os_m[c] - 1;
        T = T + 1;
      end
      for (int c = 0; c < 2; c++) xq_m[c] = xn[c];
    end
  end

  function automatic bit exp_out(int c);
    bit car;
    bit v;
    car = (((T / (f_p() + 1)) % 8) < f_d());
    if (cfg_word[0]) v = xq_m[c] && (os_m[c] > 0 || car);
    else             v = xq_m[c];
    return v ^ cfg_word[12];
  endfunction

  task automatic check(string req, bit got, bit exp, string what);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s %s got %b exp %b", req, what, got, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && cmp_on) begin
      check(cur_req, pwm_out[0], exp_out(0), "model ch A");
      check(cur_req, pwm_out[1], exp_out(1), "model ch B");
    end
  end

  task automatic tick(int n);
    repeat (n) begin @(negedge clk); #1; end
  endtask

  // reconfigure only while both post-inversion inputs are low
  task automatic change_cfg(logic [31:0] nc);
    pwm_in = cfg_word[13] ? 2'b11 : 2'b00;
    tick(2);
    cfg_word = nc;
    pwm_in = nc[13] ? 2'b11 : 2'b00;
    tick(2);
  endtask

  logic [15:0] lf = 16'hACE1;
  task automatic rand_run(int n, int hold);
    for (int i = 0; i < n; i++) begin
      if (i % hold == 0) begin
        lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
        pwm_in = lf[1:0];
      end
      tick(1);
    end
  endtask

  function automatic logic [31:0] mk(bit iinv, bit oinv, int w, int d, int p, bit en);
    return {18'h0, iinv, oinv, w[3:0], d[2:0], p[3:0], en};
  endfunction

  initial begin
    #(5 * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog run did not finish got hung exp done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int run;
    int highs;
    // R1: reset state
    tick(3);
    check("R1", pwm_out[0], 1'b0, "in reset A");
    check("R1", pwm_out[1], 1'b0, "in reset B");
    rst_n = 1'b1;
    tick(2);
    check("R1", pwm_out[0], 1'b0, "after reset A");
    check("R1", pwm_out[1], 1'b0, "after reset B");
    cmp_on = 1'b1;

    // R10: one-cycle latency in bypass
    cur_req = "R10";
    pwm_in = 2'b01;
    #1;
    check("R10", pwm_out[0], 1'b0, "before edge");
    @(negedge clk);
    check("R10", pwm_out[0], 1'b1, "after edge");
    #1;
    pwm_in = 2'b10;
    @(negedge clk);
    check("R10", pwm_out[0], 1'b0, "fall after edge");
    check("R10", pwm_out[1], 1'b1, "B rise after edge");
    #1;

    // R2: bypass under random toggling
    cur_req = "R2";
    change_cfg(mk(0, 0, 5, 3, 2, 0));
    rand_run(300, 3);

    // R4: output inversion, bypass and enabled
    cur_req = "R4";
    change_cfg(mk(0, 1, 0, 3, 1, 0));
    rand_run(200, 2);
    change_cfg(mk(0, 1, 2, 3, 1, 1));
    rand_run(400, 13);

    // R3: input inversion, bypass and enabled
    cur_req = "R3";
    change_cfg(mk(1, 0, 0, 2, 0, 0));
    rand_run(200, 4);
    change_cfg(mk(1, 0, 1, 5, 2, 1));
    rand_run(400, 17);
    change_cfg(mk(1, 1, 1, 5, 2, 1));
    rand_run(300, 11);

    // R6: carrier period for several prescales
    cur_req = "R6";
    begin
      int ps [4] = '{0, 3, 15, 2};
      int ds [4] = '{4, 2, 7, 3};
      for (int k = 0; k < 4; k++) begin
        change_cfg(mk(0, 0, 0, ds[k], ps[k], 1));
        pwm_in = 2'b01;
        highs = 0;
        for (int i = 0; i < 8 * (ps[k] + 1); i++) begin
          @(negedge clk);
          if (pwm_out[0]) highs++;
        end
        #1;
        check("R6", highs == ds[k] * (ps[k] + 1), 1'b1, "high clocks in one period");
        tick(8 * (ps[k] + 1) * 2);
        pwm_in = 2'b00;
        tick(4);
      end
    end

    // R7: duty zero gives no carrier pulses
    cur_req = "R7";
    change_cfg(mk(0, 0, 0, 0, 1, 1));
    pwm_in = 2'b11;
    tick(60);
    check("R7", pwm_out[0], 1'b0, "duty 0 A");
    check("R7", pwm_out[1], 1'b0, "duty 0 B");
    pwm_in = 2'b00;
    tick(3);
    change_cfg(mk(0, 0, 0, 1, 0, 1));
    rand_run(300, 9);

    // R8: first-pulse length
    cur_req = "R8";
    change_cfg(mk(0, 0, 3, 2, 1, 1));
    pwm_in = 2'b01;
    run = 0;
    begin
      bit go = 1'b1;
      while (go && run < 400) begin
        @(negedge clk);
        if (pwm_out[0]) run++;
        else go = 1'b0;
      end
    end
    #1;
    check("R8", run == 3 * 8 * 2 + 2 * 2, 1'b1, "first run length");
    if (run != 52) $display("  note R8 run %0d", run);
    pwm_in = 2'b00;
    tick(4);
    change_cfg(mk(0, 0, 15, 6, 0, 1));
    rand_run(600, 40);

    // R5: low input forces inactive level while enabled
    cur_req = "R5";
    change_cfg(mk(0, 0, 2, 7, 0, 1));
    pwm_in = 2'b00;
    tick(20);
    check("R5", pwm_out[0], 1'b0, "low input A");
    check("R5", pwm_out[1], 1'b0, "low input B");

    // R9: B rises while A is mid-interval; restart and separate one-shots
    cur_req = "R9";
    change_cfg(mk(0, 0, 2, 3, 1, 1));
    pwm_in = 2'b01;
    tick(21);
    pwm_in = 2'b11;
    tick(120);
    pwm_in = 2'b00;
    tick(4);
    rand_run(1500, 7);

    cmp_on = 1'b0;
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule